// File: doc/BRIEF.md
# Adjacent-Sample Conversion Error Checker

This block is a self-test monitor that watches a converter's output code stream while the converter digitises a slow, phase-locked input. Under that input two consecutive codes should differ by little more than one code. Every valid sample is compared with the sample before it. When the absolute step is larger than an error limit, the sample is counted as a conversion error. The limit is a single code count that covers the combined benign error sources.

For every violation the block keeps the offending code, its 64-bit sample index and its margin, which is the step minus the limit. It keeps one record that holds the first violation since the last restart, and a second record that always holds the most recent one. It also counts errors and builds a histogram of step magnitudes, so that the tail of the distribution beyond the limit can be inspected over a long run.

A restart input clears the whole measurement, for example after a supply glitch has spoiled it. An enable input pauses checking without losing any state.

Top module: `adj_step_monitor`

## Requirements
- R1: On a checked sample, the block flags an error when the absolute step |sample(N) - sample(N-1)| is strictly greater than the active limit. A step equal to the limit is not an error.
- R2: The first-error record captures the code, the index and the margin (step minus limit) of the earliest violation since reset or restart. Later violations leave this record unchanged.
- R3: The last-error record is overwritten by every violation with that violation's code, index and margin.
- R4: When `useDefaultLimit` is 1, the active limit is 12 << (SAMPLE_W-12) and `limitIn` is ignored. When it is 0, the active limit is `limitIn`.
- R5: `sampleCount` is 64 bits wide and counts every valid sample. The index of a sample is the value of `sampleCount` before that sample, so the first sample after reset or restart has index 0.
- R6: Each checked sample adds one to histogram bin min(step, HIST_BINS-1). The last bin therefore collects all larger steps. `histData` returns the bin selected by `histSel`.
- R7: The error counter saturates at its maximum value, and so does every histogram bin counter.
- R8: A restart pulse clears the sample count, the error count, both records and the histogram. A valid sample presented in the same cycle as the restart is discarded.
- R9: The first valid sample after reset or restart only loads the previous-sample register. It is never checked and never enters the histogram.
- R10: While `enable` is 0, valid samples are counted and update the previous-sample register, but they are not checked and do not enter the histogram. The first sample after `enable` returns to 1 is compared with the last sample seen while paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Synchronous clear of the whole measurement |
| enable | input | 1 | Checking enable |
| useDefaultLimit | input | 1 | Use the resolution-scaled default limit |
| limitIn | input | SAMPLE_W+1 | Programmed step limit in codes |
| sampleValid | input | 1 | Sample strobe |
| sample | input | SAMPLE_W | Offset-binary converter code |
| histSel | input | clog2(HIST_BINS) | Histogram bin select |
| histData | output | BIN_W | Count in the selected bin |
| sampleCount | output | 64 | Number of valid samples since clear |
| errCount | output | ERR_W | Saturating error count |
| firstValid | output | 1 | First-error record holds data |
| firstSample | output | SAMPLE_W | Code of the first violation |
| firstIndex | output | 64 | Index of the first violation |
| firstMargin | output | SAMPLE_W+1 | Margin of the first violation |
| lastValid | output | 1 | Last-error record holds data |
| lastSample | output | SAMPLE_W | Code of the latest violation |
| lastIndex | output | 64 | Index of the latest violation |
| lastMargin | output | SAMPLE_W+1 | Margin of the latest violation |

## Verification
The assertions check on every cycle several properties of the counters and records. The sample count advances by exactly one per valid sample. The error count never falls except on a restart. The first-error record stays stable once it is set. A restart leaves every count and record cleared. The control is also checked so that it never requests a check without a previous sample. The bench's scenarios cover what depends on arithmetic over chosen sequences. These include a step exactly at the limit against one code above it, and the margin values of the captured records. They also include the overflow bin and saturation of the error and bin counters, the default limit overriding the programmed one, and a pause during which a large jump is absorbed without an error.

// File: rtl/adj_step_pkg.sv
package adj_step_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic check;
    logic logErr;
  } stepStrobes_t;
endpackage

// File: rtl/step_ctrl.sv
module step_ctrl
  import adj_step_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         enable,
  input  logic         sampleValid,
  input  logic         overLimit,
  output stepStrobes_t strb
);
  logic havePrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          havePrev <= 1'b0;
    else if (restart)    havePrev <= 1'b0;
    else if (sampleValid) havePrev <= 1'b1;
  end

  always_comb begin
    strb.clear  = restart;
    strb.load   = sampleValid && !restart;
    strb.check  = sampleValid && !restart && enable && havePrev;
    strb.logErr = sampleValid && !restart && enable && havePrev && overLimit;
  end

  AST_NO_FIRST_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || !havePrev) |-> !strb.check) else $error("first sample checked"); // R9
  AST_PAUSE_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !strb.check && !strb.logErr) else $error("check while paused"); // R10
endmodule

// File: rtl/step_datapath.sv
module step_datapath
  import adj_step_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int HIST_BINS = 16,
  parameter int BIN_W     = 16,
  parameter int ERR_W     = 16,
  parameter int IDX_W     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  stepStrobes_t                 strb,
  input  logic                         useDefaultLimit,
  input  logic [SAMPLE_W:0]            limitIn,
  input  logic [SAMPLE_W-1:0]          sample,
  input  logic [$clog2(HIST_BINS)-1:0] histSel,
  output logic                         overLimit,
  output logic [BIN_W-1:0]             histData,
  output logic [IDX_W-1:0]             sampleCount,
  output logic [ERR_W-1:0]             errCount,
  output logic                         firstValid,
  output logic [SAMPLE_W-1:0]          firstSample,
  output logic [IDX_W-1:0]             firstIndex,
  output logic [SAMPLE_W:0]            firstMargin,
  output logic                         lastValid,
  output logic [SAMPLE_W-1:0]          lastSample,
  output logic [IDX_W-1:0]             lastIndex,
  output logic [SAMPLE_W:0]            lastMargin
);
  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int BIDX_W = $clog2(HIST_BINS);
  localparam int DEF_LIMIT_I = 12 << (SAMPLE_W - 12);
  localparam logic [DIFF_W-1:0] DEF_LIMIT = DIFF_W'(DEF_LIMIT_I);
  localparam logic [DIFF_W-1:0] LAST_BIN  = DIFF_W'(HIST_BINS - 1);
  localparam logic [ERR_W-1:0]  ERR_MAX   = '1;
  localparam logic [BIN_W-1:0]  BIN_MAX   = '1;

  logic [SAMPLE_W-1:0] prevSample;
  logic [DIFF_W-1:0]   diff, stepMag, activeLimit, margin;
  logic [BIDX_W-1:0]   binIdx;
  logic [BIN_W-1:0]    hist [HIST_BINS];

  always_comb begin
    diff        = {1'b0, sample} - {1'b0, prevSample};
    stepMag     = diff[DIFF_W-1] ? (~diff + 1'b1) : diff;
    activeLimit = useDefaultLimit ? DEF_LIMIT : limitIn;
    overLimit   = stepMag > activeLimit;
    margin      = stepMag - activeLimit;
    binIdx      = (stepMag >= LAST_BIN) ? BIDX_W'(HIST_BINS - 1) : stepMag[BIDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSample  <= '0;
      sampleCount <= '0;
    end else if (strb.clear) begin
      sampleCount <= '0;
    end else if (strb.load) begin
      prevSample  <= sample;
      sampleCount <= sampleCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || 1'b0) begin
      errCount <= '0;
      firstValid <= 1'b0; firstSample <= '0; firstIndex <= '0; firstMargin <= '0;
      lastValid  <= 1'b0; lastSample  <= '0; lastIndex  <= '0; lastMargin  <= '0;
    end else if (strb.clear) begin
      errCount <= '0;
      firstValid <= 1'b0; firstSample <= '0; firstIndex <= '0; firstMargin <= '0;
      lastValid  <= 1'b0; lastSample  <= '0; lastIndex  <= '0; lastMargin  <= '0;
    end else if (strb.logErr) begin
      if (errCount != ERR_MAX) errCount <= errCount + 1'b1;
      if (!firstValid) begin
        firstValid  <= 1'b1;
        firstSample <= sample;
        firstIndex  <= sampleCount;
        firstMargin <= margin;
      end
      lastValid  <= 1'b1;
      lastSample <= sample;
      lastIndex  <= sampleCount;
      lastMargin <= margin;
    end
  end

  for (genvar b = 0; b < HIST_BINS; b++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  hist[b] <= '0;
      else if (strb.clear)                         hist[b] <= '0;
      else if (strb.check && binIdx == BIDX_W'(b) && hist[b] != BIN_MAX)
                                                   hist[b] <= hist[b] + 1'b1;
    end
  end

  assign histData = hist[histSel];

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> sampleCount == $past(sampleCount) + 1'b1) else $error("count step"); // R5
  AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clear |=> errCount >= $past(errCount)) else $error("error count fell"); // R7
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (firstValid && !strb.clear) |=> $stable(firstIndex) && $stable(firstMargin) && $stable(firstSample))
    else $error("first record changed"); // R2
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> sampleCount == '0 && errCount == '0 && !firstValid && !lastValid)
    else $error("restart incomplete"); // R8
  AST_LAST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.logErr |=> lastValid && lastIndex == $past(sampleCount)) else $error("last index"); // R3
endmodule

// File: rtl/adj_step_monitor.sv
module adj_step_monitor
  import adj_step_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int HIST_BINS = 16,
  parameter int BIN_W     = 16,
  parameter int ERR_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         restart,
  input  logic                         enable,
  input  logic                         useDefaultLimit,
  input  logic [SAMPLE_W:0]            limitIn,
  input  logic                         sampleValid,
  input  logic [SAMPLE_W-1:0]          sample,
  input  logic [$clog2(HIST_BINS)-1:0] histSel,
  output logic [BIN_W-1:0]             histData,
  output logic [63:0]                  sampleCount,
  output logic [ERR_W-1:0]             errCount,
  output logic                         firstValid,
  output logic [SAMPLE_W-1:0]          firstSample,
  output logic [63:0]                  firstIndex,
  output logic [SAMPLE_W:0]            firstMargin,
  output logic                         lastValid,
  output logic [SAMPLE_W-1:0]          lastSample,
  output logic [63:0]                  lastIndex,
  output logic [SAMPLE_W:0]            lastMargin
);
  stepStrobes_t strb;
  logic overLimit;

  step_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .enable(enable),
    .sampleValid(sampleValid), .overLimit(overLimit), .strb(strb)
  );

  step_datapath #(
    .SAMPLE_W(SAMPLE_W), .HIST_BINS(HIST_BINS), .BIN_W(BIN_W),
    .ERR_W(ERR_W), .IDX_W(64)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .useDefaultLimit(useDefaultLimit),
    .limitIn(limitIn), .sample(sample), .histSel(histSel), .overLimit(overLimit),
    .histData(histData), .sampleCount(sampleCount), .errCount(errCount),
    .firstValid(firstValid), .firstSample(firstSample), .firstIndex(firstIndex),
    .firstMargin(firstMargin), .lastValid(lastValid), .lastSample(lastSample),
    .lastIndex(lastIndex), .lastMargin(lastMargin)
  );
endmodule

// File: tb/tb_adj_step_monitor.sv
`timescale 1ns/1ps
module tb_adj_step_monitor;
  localparam int SW = 12, NB = 8, BW = 4, EW = 4;
  localparam int BMAX = 15, EMAX = 15;

  logic clk = 0, rst_n = 0, restart = 0, enable = 1, useDefaultLimit = 0;
  logic [SW:0] limitIn = 13'd12;
  logic sampleValid = 0;
  logic [SW-1:0] sample = '0;
  logic [2:0] histSel = '0;
  logic [BW-1:0] histData;
  logic [63:0] sampleCount, firstIndex, lastIndex;
  logic [EW-1:0] errCount;
  logic firstValid, lastValid;
  logic [SW-1:0] firstSample, lastSample;
  logic [SW:0] firstMargin, lastMargin;

  always #4 clk = ~clk;

  adj_step_monitor #(.SAMPLE_W(SW), .HIST_BINS(NB), .BIN_W(BW), .ERR_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .enable(enable),
    .useDefaultLimit(useDefaultLimit), .limitIn(limitIn), .sampleValid(sampleValid),
    .sample(sample), .histSel(histSel), .histData(histData), .sampleCount(sampleCount),
    .errCount(errCount), .firstValid(firstValid), .firstSample(firstSample),
    .firstIndex(firstIndex), .firstMargin(firstMargin), .lastValid(lastValid),
    .lastSample(lastSample), .lastIndex(lastIndex), .lastMargin(lastMargin)
  );

  typedef struct {
    string tag; longint cnt; int err; bit fv; int fs; longint fi; int fm;
    bit lv; int ls; longint li; int lm;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, errors = 0;
  bit mHave = 0; int mPrev = 0; longint mCnt = 0; int mErr = 0;
  bit mFv = 0; int mFs = 0; longint mFi = 0; int mFm = 0;
  bit mLv = 0; int mLs = 0; longint mLi = 0; int mLm = 0;
  int mHist[NB];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    mHave = 0; mCnt = 0; mErr = 0; mFv = 0; mFs = 0; mFi = 0; mFm = 0;
    mLv = 0; mLs = 0; mLi = 0; mLm = 0;
    for (int i = 0; i < NB; i++) mHist[i] = 0;
  endtask

  // driver: one valid sample, model update, expected item pushed
  task automatic drive(string tag, int s, bit en);
    exp_t e;
    int mag, lim, bin;
    @(negedge clk);
    sample = SW'(s); sampleValid = 1; enable = en;
    if (mHave && en) begin
      mag = (s > mPrev) ? s - mPrev : mPrev - s;
      lim = useDefaultLimit ? 12 : int'(limitIn);
      bin = (mag >= NB - 1) ? NB - 1 : mag;
      if (mHist[bin] < BMAX) mHist[bin]++;
      if (mag > lim) begin
        if (mErr < EMAX) mErr++;
        if (!mFv) begin mFv = 1; mFs = s; mFi = mCnt; mFm = mag - lim; end
        mLv = 1; mLs = s; mLi = mCnt; mLm = mag - lim;
      end
    end
    mPrev = s; mHave = 1; mCnt++;
    @(posedge clk); #1;
    sampleValid = 0;
    e.tag = tag; e.cnt = mCnt; e.err = mErr; e.fv = mFv; e.fs = mFs; e.fi = mFi; e.fm = mFm;
    e.lv = mLv; e.ls = mLs; e.li = mLi; e.lm = mLm;
    expQ.push_back(e);
  endtask

  // monitor: compares registered outputs one half cycle after the capturing edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk({e.tag, " R5 sampleCount"}, longint'(sampleCount), e.cnt);
      chk({e.tag, " R1/R7 errCount"}, longint'(errCount), e.err);
      chk({e.tag, " R2 firstValid"}, longint'(firstValid), e.fv);
      chk({e.tag, " R2 firstSample"}, longint'(firstSample), e.fs);
      chk({e.tag, " R2 firstIndex"}, longint'(firstIndex), e.fi);
      chk({e.tag, " R2 firstMargin"}, longint'(firstMargin), e.fm);
      chk({e.tag, " R3 lastValid"}, longint'(lastValid), e.lv);
      chk({e.tag, " R3 lastSample"}, longint'(lastSample), e.ls);
      chk({e.tag, " R3 lastIndex"}, longint'(lastIndex), e.li);
      chk({e.tag, " R3 lastMargin"}, longint'(lastMargin), e.lm);
    end
  end

  task automatic checkHist(string tag);
    @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      histSel = 3'(i); #1;
      chk({tag, " R6 hist bin"}, longint'(histData), mHist[i]);
    end
  endtask

  task automatic doRestart(int s);
    @(negedge clk);
    restart = 1; sample = SW'(s); sampleValid = 1;
    @(posedge clk); #1;
    restart = 0; sampleValid = 0;
    modelClear();
    @(negedge clk);
    chk("R8 restart sampleCount", longint'(sampleCount), 0);
    chk("R8 restart errCount", longint'(errCount), 0);
    chk("R8 restart firstValid", longint'(firstValid), 0);
    chk("R8 restart lastValid", longint'(lastValid), 0);
  endtask

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    chk("R8 reset sampleCount", longint'(sampleCount), 0);
    chk("R8 reset errCount", longint'(errCount), 0);
    chk("R8 reset firstValid", longint'(firstValid), 0);
    rst_n = 1;
    drive("R9 first sample", 3000, 1);
    drive("ramp", 3001, 1);
    drive("ramp", 3002, 1);
    drive("ramp", 3000, 1);
    drive("R1 step equal limit", 3012, 1);
    drive("R1 step limit+1", 2999, 1);
    drive("R3 second error", 2979, 1);
    drive("R6 big step", 2929, 1);
    checkHist("R6 after ramp");
    limitIn = 13'd3; useDefaultLimit = 1;
    drive("R4 default limit step 10", 2939, 1);
    drive("R4 default limit step 13", 2926, 1);
    useDefaultLimit = 0; limitIn = 13'd12;
    drive("R10 paused jump", 100, 0);
    drive("R10 paused jump", 1200, 0);
    drive("R10 resumed small step", 1201, 1);
    checkHist("R10 after pause");
    for (int i = 0; i < 20; i++) drive("R7 saturate", (i % 2 == 0) ? 1300 : 1201, 1);
    checkHist("R7 bin saturation");
    doRestart(4000);
    checkHist("R8 hist cleared");
    drive("R9 first after restart", 500, 1);
    drive("R8 post restart step", 505, 1);
    checkHist("R9 after restart");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule